// File: doc/BRIEF.md
# Alert Response Responder

This block is the device-side half of the alert-response exchange on a two-wire open-drain serial bus. A device that has raised its shared alert line must say who it is when the bus master polls for alerts. The master polls with a read transaction sent to a fixed, reserved address. The block watches the sampled clock and data lines and tracks START and STOP conditions and the bits of each address byte. It takes part only when that reserved address arrives with the read direction bit and this device has an alert pending.

When it takes part, it acknowledges the address byte. It then shifts out a data byte that holds its own 7-bit address in the upper seven bits, followed by a released (logic 1) bit. Several devices may answer at the same time, and the bus wires their outputs together as a wired-AND. Each bit the block releases is therefore compared with the bus level on the rising clock edge. If the bus reads low when the block has released it, another responder with a lower address has won the exchange. The block then stops driving and raises a lost flag. When the whole byte goes out without a loss, the block pulses an acknowledged strobe as the master's acknowledge bit is clocked in. The surrounding logic uses that strobe to clear its pending alert. A device that loses keeps its alert and answers again on a later poll.

Top module: `alert_resp_unit`

## Requirements
- R1: After reset the SDA pull-low enable, the acknowledged strobe and the lost flag are all 0.
- R2: A byte of 0x19 (reserved address 0x0C in bits 7:1, read bit 1 in bit 0), received after START while the alert-pending input is 1, is acknowledged: the bus reads 0 during the ninth clock.
- R3: While the alert-pending input is 0, the block never drives SDA, even for byte 0x19, and gives no strobe.
- R4: An address byte other than 0x19, including the write form 0x18, is not acknowledged, and the block does not drive SDA for the rest of that transaction.
- R5: After acknowledging, the block sends its own 7-bit address MSB first in bits 7:1 of the data byte. For a 0 bit it pulls SDA low, and for a 1 bit it releases SDA. The pull-low enable only turns on while SCL is low.
- R6: Bit 0 of the returned byte is always released (reads 1 when no other device drives).
- R7: If SDA is sampled low at an SCL rising edge during a bit the block has released, the lost flag is set. The block then stops driving for the rest of the byte and gives no strobe. A contender with a higher address does not make the block lose.
- R8: After a byte sent without a loss, the acknowledged strobe is high for exactly one clock cycle, one cycle after the SCL rising edge of the master's acknowledge bit.
- R9: A START, including a repeated START in the middle of a response, clears the lost flag, releases SDA and restarts address reception.
- R10: A STOP releases SDA and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line (wired-AND level) |
| own_addr_i | input | 7 | This device's 7-bit bus address |
| alert_pend_i | input | 1 | This device has an alert outstanding |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| alert_ack_o | output | 1 | One-cycle strobe: response byte won and acknowledged |
| arb_lost_o | output | 1 | Arbitration lost in the current response |

## Verification
A bit counter that is off by one shows up as a shifted or truncated returned byte, or as an acknowledge that lands on the wrong clock. The bench catches this on the first poll, within one byte time. A wrong arbitration state shows within the same byte in one of three ways: the block drives after a loss, so the bus reads a mix of the two addresses; the strobe fires after a loss; or the lost flag goes up against a contender with a higher address. A stale sequencer state that START or STOP did not clear shows as SDA still pulled after STOP. It also shows as a missing acknowledge on the poll that follows a repeated START.

// File: rtl/ara_pkg.sv
package ara_pkg;
  localparam int unsigned ADDR_W_DEF = 7;
  localparam logic [ADDR_W_DEF-1:0] ARA_ADDR_DEF = 7'h0C;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_SEND,
    ST_MACK,
    ST_DONE
  } resp_state_e;
endpackage

// File: rtl/ara_bus_cond.sv
module ara_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;
  logic scl_d, sda_d;

  always_comb begin
    scl_d = scl_i;
    sda_d = sda_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  always_comb begin
    start_o = scl_q && scl_i && sda_q && !sda_i;
    stop_o  = scl_q && scl_i && !sda_q && sda_i;
    rise_o  = !scl_q && scl_i;
    fall_o  = scl_q && !scl_i;
  end
endmodule

// File: rtl/ara_addr_match.sv
module ara_addr_match #(
  parameter int unsigned ADDR_W = 7,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'h0C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic shift_en_i,
  input  logic sda_i,
  output logic hit_o
);
  logic [ADDR_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (clr_i) begin
      sh_d = '0;
    end else if (shift_en_i) begin
      sh_d = {sh_q[ADDR_W-2:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  // Byte is complete on the eighth rising edge: seven held bits plus the live R/W bit.
  always_comb begin
    hit_o = ({sh_q, sda_i} == {ARA_ADDR, 1'b1});
  end
endmodule

// File: rtl/ara_tx_arb.sv
module ara_tx_arb #(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned BYTE_W = ADDR_W + 1,
  localparam int unsigned CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic              rise_i,
  input  logic              pulling_i,
  input  logic              sda_i,
  output logic              bit_o,
  output logic              lost_now_o
);
  logic [BYTE_W-1:0] tx_q, tx_d;

  always_comb begin
    tx_d = tx_q;
    if (load_i) begin
      tx_d = {own_addr_i, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '1;
    end else begin
      tx_q <= tx_d;
    end
  end

  // MSB-first bit selection.
  always_comb begin
    bit_o = 1'b1;
    for (int i = 0; i < BYTE_W; i++) begin
      if (idx_i == CNT_W'(i)) begin
        bit_o = tx_q[BYTE_W-1-i];
      end
    end
  end

  // Released line seen low at the sampling edge means another responder won.
  always_comb begin
    lost_now_o = rise_i && !pulling_i && !sda_i;
  end
endmodule

// File: rtl/ara_ctrl.sv
module ara_ctrl
  import ara_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned BYTE_W = ADDR_W + 1,
  localparam int unsigned CNT_W = $clog2(BYTE_W),
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             hit_i,
  input  logic             pend_i,
  input  logic             tx_bit_i,
  input  logic             lost_now_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             shift_en_o,
  output logic             shift_clr_o,
  output logic             load_o,
  output logic             pull_o,
  output logic             ack_o,
  output logic             lost_o
);
  resp_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pull_q, pull_d;
  logic             lost_q, lost_d;
  logic             ack_q, ack_d;

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    pull_d      = pull_q;
    lost_d      = lost_q;
    ack_d       = 1'b0;
    shift_en_o  = 1'b0;
    shift_clr_o = 1'b0;
    load_o      = 1'b0;

    if (stop_i) begin
      st_d   = ST_IDLE;
      pull_d = 1'b0;
      cnt_d  = '0;
    end else if (start_i) begin
      st_d        = ST_ADDR;
      cnt_d       = '0;
      pull_d      = 1'b0;
      lost_d      = 1'b0;
      shift_clr_o = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          pull_d = 1'b0;
        end
        ST_ADDR: begin
          if (rise_i) begin
            shift_en_o = 1'b1;
            if (cnt_q == LAST_IDX) begin
              cnt_d = '0;
              if (hit_i && pend_i) begin
                st_d   = ST_ACK;
                load_o = 1'b1;
              end else begin
                st_d = ST_DONE;
              end
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (fall_i) begin
            if (!pull_q) begin
              pull_d = 1'b1;
            end else begin
              st_d   = ST_SEND;
              pull_d = !tx_bit_i;
            end
          end
        end
        ST_SEND: begin
          if (lost_now_i) begin
            lost_d = 1'b1;
            pull_d = 1'b0;
            st_d   = ST_DONE;
          end else if (rise_i) begin
            if (cnt_q == LAST_IDX) begin
              cnt_d = '0;
              st_d  = ST_MACK;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else if (fall_i) begin
            pull_d = !tx_bit_i;
          end
        end
        ST_MACK: begin
          if (fall_i) begin
            pull_d = 1'b0;
          end
          if (rise_i) begin
            ack_d  = 1'b1;
            pull_d = 1'b0;
            st_d   = ST_DONE;
          end
        end
        ST_DONE: begin
          pull_d = 1'b0;
        end
        default: begin
          st_d   = ST_IDLE;
          pull_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pull_q <= 1'b0;
      lost_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      pull_q <= pull_d;
      lost_q <= lost_d;
      ack_q  <= ack_d;
    end
  end

  always_comb begin
    idx_o  = cnt_q;
    pull_o = pull_q;
    ack_o  = ack_q;
    lost_o = lost_q;
  end
endmodule

// File: rtl/alert_resp_unit.sv
module alert_resp_unit
  import ara_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] ARA_ADDR = ARA_ADDR_DEF,
  localparam int unsigned BYTE_W = ADDR_W + 1,
  localparam int unsigned CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              alert_pend_i,
  output logic              sda_pull_o,
  output logic              alert_ack_o,
  output logic              arb_lost_o
);
  logic rst_s1_q, rst_s2_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  always_comb rst_sync_n = rst_s2_q;

  logic start_w, stop_w, rise_w, fall_w;
  logic hit_w, shift_en_w, shift_clr_w, load_w;
  logic tx_bit_w, lost_now_w;
  logic [CNT_W-1:0] idx_w;

  ara_bus_cond u_cond (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .start_o (start_w),
    .stop_o  (stop_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  ara_addr_match #(.ADDR_W(ADDR_W), .ARA_ADDR(ARA_ADDR)) u_match (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr_i      (shift_clr_w),
    .shift_en_i (shift_en_w),
    .sda_i      (sda_i),
    .hit_o      (hit_w)
  );

  ara_tx_arb #(.ADDR_W(ADDR_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (load_w),
    .own_addr_i (own_addr_i),
    .idx_i      (idx_w),
    .rise_i     (rise_w),
    .pulling_i  (sda_pull_o),
    .sda_i      (sda_i),
    .bit_o      (tx_bit_w),
    .lost_now_o (lost_now_w)
  );

  ara_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_w),
    .stop_i      (stop_w),
    .rise_i      (rise_w),
    .fall_i      (fall_w),
    .hit_i       (hit_w),
    .pend_i      (alert_pend_i),
    .tx_bit_i    (tx_bit_w),
    .lost_now_i  (lost_now_w),
    .idx_o       (idx_w),
    .shift_en_o  (shift_en_w),
    .shift_clr_o (shift_clr_w),
    .load_o      (load_w),
    .pull_o      (sda_pull_o),
    .ack_o       (alert_ack_o),
    .lost_o      (arb_lost_o)
  );
endmodule

// File: rtl/ara_resp_chk.sv
module ara_resp_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_i,
  input logic sda_pull_o,
  input logic alert_ack_o,
  input logic arb_lost_o
);
  // R5
  pull_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_i);

  // R7
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost_o |-> !sda_pull_o);

  // R7
  lost_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost_o |-> !alert_ack_o);

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert_ack_o |=> !alert_ack_o);

  // R8
  strobe_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert_ack_o |-> ($past(scl_i) && !$past(scl_i, 2)));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_pull_o);
endmodule

bind alert_resp_unit ara_resp_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_i       (scl_i),
  .sda_i       (sda_i),
  .sda_pull_o  (sda_pull_o),
  .alert_ack_o (alert_ack_o),
  .arb_lost_o  (arb_lost_o)
);

// File: tb/alert_resp_unit_tb.sv
module alert_resp_unit_tb;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic scl, sda_m, other_pull;
  logic [6:0] own_addr;
  logic alert_pend;
  logic sda_pull, alert_ack, arb_lost;
  wire  sda_bus = sda_m & ~sda_pull & ~other_pull;

  always #(CLK_NS/2) clk = ~clk;

  alert_resp_unit u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl),
    .sda_i        (sda_bus),
    .own_addr_i   (own_addr),
    .alert_pend_i (alert_pend),
    .sda_pull_o   (sda_pull),
    .alert_ack_o  (alert_ack),
    .arb_lost_o   (arb_lost)
  );

  typedef struct { string req; int val; } item_t;
  item_t exp_q[$];
  int    obs_q[$];
  int    checks = 0;
  int    errors = 0;
  int    ack_cnt = 0;
  logic  pull_seen = 1'b0;
  logic  other_on = 1'b0;
  logic [7:0] other_byte = 8'hFF;
  int    other_idx = 0;
  bit    done = 0;

  // Driver side: expected values.
  task automatic expect_val(input string r, input int v);
    exp_q.push_back('{r, v});
  endtask

  task automatic observe(input int v);
    obs_q.push_back(v);
  endtask

  // Monitor: pops and compares.
  always @(negedge clk) begin
    if (obs_q.size() > 0 && exp_q.size() > 0) begin
      item_t e;
      int o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      checks++;
      if (o !== e.val) begin
        errors++;
        $display("FAIL %s: got 0x%0h expected 0x%0h", e.req, o, e.val);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && alert_ack) ack_cnt++;
    if (sda_pull) pull_seen = 1'b1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(2);
    scl = 1'b1;   tick(2);
    sda_m = 1'b0; tick(2);
    scl = 1'b0;   tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(2);
    scl = 1'b1;   tick(2);
    sda_m = 1'b1; tick(2);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;  tick(2);
    scl = 1'b1; tick(2);
    scl = 1'b0; tick(2);
  endtask

  task automatic get_bit(output logic b);
    logic ob;
    ob = other_byte[7 - other_idx];
    sda_m = 1'b1;
    other_pull = other_on & ~ob;
    tick(2);
    scl = 1'b1; tick(1);
    b = sda_bus;
    if (other_on && ob && !b) other_on = 1'b0;
    tick(1);
    scl = 1'b0; tick(2);
    if (other_idx < 7) other_idx++;
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic get_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      get_bit(b);
      v[i] = b;
    end
    other_pull = 1'b0;
    other_on = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic b;
    logic [7:0] v;
    int a0;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; other_pull = 1'b0;
    own_addr = 7'h2A; alert_pend = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    expect_val("R1 pull", 0); observe(sda_pull);
    expect_val("R1 strobe", 0); observe(alert_ack);
    expect_val("R1 lost", 0); observe(arb_lost);

    // R2 R5 R6 R8 single responder wins
    alert_pend = 1'b1; a0 = ack_cnt;
    bus_start(); put_byte(8'h19); get_bit(b);
    expect_val("R2 ack bit", 0); observe(b);
    get_byte(v);
    expect_val("R5 returned byte", 8'h55); observe(v);
    expect_val("R6 lsb released", 1); observe(v[0]);
    put_bit(1'b1); tick(2);
    expect_val("R8 one strobe cycle", a0 + 1); observe(ack_cnt);
    expect_val("R8 lost clear", 0); observe(arb_lost);
    bus_stop(); tick(2);
    expect_val("R10 released after stop", 0); observe(sda_pull);

    // R5 second own address pattern
    own_addr = 7'h0F; a0 = ack_cnt;
    bus_start(); put_byte(8'h19); get_bit(b);
    expect_val("R2 ack bit addr 0F", 0); observe(b);
    get_byte(v);
    expect_val("R5 returned byte addr 0F", 8'h1F); observe(v);
    put_bit(1'b1); tick(2);
    expect_val("R8 strobe addr 0F", a0 + 1); observe(ack_cnt);
    bus_stop(); tick(2);
    own_addr = 7'h2A;

    // R3 no alert pending
    alert_pend = 1'b0; pull_seen = 1'b0; a0 = ack_cnt;
    bus_start(); put_byte(8'h19); get_bit(b);
    expect_val("R3 no ack", 1); observe(b);
    get_byte(v);
    expect_val("R3 bus idle byte", 8'hFF); observe(v);
    put_bit(1'b1); bus_stop(); tick(2);
    expect_val("R3 never pulled", 0); observe(pull_seen);
    expect_val("R3 no strobe", a0); observe(ack_cnt);

    // R4 other addresses
    alert_pend = 1'b1; pull_seen = 1'b0;
    bus_start(); put_byte(8'h18); get_bit(b);
    expect_val("R4 write form no ack", 1); observe(b);
    get_byte(v); bus_stop(); tick(2);
    bus_start(); put_byte(8'hA1); get_bit(b);
    expect_val("R4 foreign addr no ack", 1); observe(b);
    get_byte(v); bus_stop(); tick(2);
    expect_val("R4 never pulled", 0); observe(pull_seen);

    // R7 lower contender 0x29 wins
    a0 = ack_cnt;
    bus_start(); put_byte(8'h19); get_bit(b);
    expect_val("R7 ack bit", 0); observe(b);
    other_byte = 8'h53; other_idx = 0; other_on = 1'b1;
    get_byte(v);
    expect_val("R7 bus carries winner", 8'h53); observe(v);
    expect_val("R7 lost flag", 1); observe(arb_lost);
    expect_val("R7 released", 0); observe(sda_pull);
    put_bit(1'b0); tick(2);
    expect_val("R7 no strobe", a0); observe(ack_cnt);
    bus_stop(); tick(2);

    // R9 START clears lost flag
    bus_start();
    expect_val("R9 lost cleared", 0); observe(arb_lost);
    put_byte(8'h19); get_bit(b);
    get_byte(v);
    expect_val("R9 answers after clear", 8'h55); observe(v);
    put_bit(1'b1); bus_stop(); tick(2);

    // R7 higher contender 0x2B loses to this device
    a0 = ack_cnt;
    bus_start(); put_byte(8'h19); get_bit(b);
    other_byte = 8'h57; other_idx = 0; other_on = 1'b1;
    get_byte(v);
    expect_val("R7 win over higher", 8'h55); observe(v);
    expect_val("R7 not lost", 0); observe(arb_lost);
    put_bit(1'b0); tick(2);
    expect_val("R7 strobe on win", a0 + 1); observe(ack_cnt);
    bus_stop(); tick(2);

    // R9 repeated START mid-response
    a0 = ack_cnt;
    bus_start(); put_byte(8'h19); get_bit(b);
    get_bit(b); get_bit(b); get_bit(b);
    bus_start();
    put_byte(8'h19); get_bit(b);
    expect_val("R9 ack after restart", 0); observe(b);
    get_byte(v);
    expect_val("R9 full byte after restart", 8'h55); observe(v);
    put_bit(1'b1); tick(2);
    expect_val("R9 single strobe", a0 + 1); observe(ack_cnt);
    bus_stop(); tick(2);
    expect_val("R10 idle released", 0); observe(sda_pull);

    tick(6);
    if (exp_q.size() != 0 || obs_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: got %0d leftover expected 0", exp_q.size() + obs_q.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule